// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Datapath

This block is the arithmetic core of a small 16-bit fixed-point signal processor. It holds two multiplier operand registers, a 32-bit product register and a 40-bit accumulator. Values are two's-complement fractions in [-1, 1), where 0x8000 is -1.0 and 0x7FFF is the largest positive value. Whenever an operand register is written, the fractional product of the two operands is formed in the same cycle. That product either replaces the product register or is added to its previous contents, which gives a single-cycle multiply-accumulate.

An ALU updates the accumulator. It takes its source from either the accumulator itself or the product register, and can add, subtract, shift, toggle one bit, or clamp the 40-bit value into the 32-bit range. The upper 8 bits of the accumulator are guard bits, so intermediate sums can pass the 32-bit limit without wrapping. Every operation is one opcode presented with `opValid` for one clock. All results are registered and visible on the outputs after that edge.

Top module: `fmac_unit`

## Requirements
- R1: After reset is asserted (`rstN` low), every register is zero: X, Y, the product, the 40-bit accumulator, and the overflow flag.
- R2: Opcode 1 loads X from `xIn`, opcode 2 loads Y from `yIn`, and opcode 4 loads both. Each of these overwrites the product with the fractional product of the new X and Y values (a register that is not loaded keeps its held value).
- R3: The fractional product is the signed 16x16 product shifted left by one bit. The single case 0x8000 times 0x8000 gives 0x7FFF_FFFF.
- R4: Opcode 3 (MAC) loads X and Y together and adds their fractional product to the previous product, modulo 2^32, in one cycle.
- R5: For ALU opcodes, `srcSel`=0 selects the 40-bit accumulator as the source. `srcSel`=1 selects the product register, sign-extended to 40 bits.
- R6: Opcode 5 sets the accumulator to accumulator plus source, and opcode 6 sets it to accumulator minus source. Both use 40-bit arithmetic, so sums beyond the 32-bit range stay exact in the guard bits.
- R7: Opcode 7 shifts the source left by `shAmt`. Opcode 8 shifts it right arithmetically and opcode 9 shifts it right logically, both over all 40 bits. The result is written to the accumulator.
- R8: Opcode 10 inverts accumulator bit `shAmt` (0 to 39, where 39 is the top guard bit) and leaves every other bit unchanged.
- R9: Opcode 11 clamps the accumulator when the guard bits differ from bit 31. A positive value becomes 0x00_7FFF_FFFF and a negative value becomes 0xFF_8000_0000. A clamp sets `ovfFlag`, which stays set until reset. An in-range value is left unchanged.
- R10: With `opValid` low, or with opcode 0 or 12 to 15, no register changes. Operand-load opcodes (1 to 4) leave the accumulator unchanged, and ALU opcodes (5 to 11) leave X, Y and the product unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Execute `opCode` at this edge |
| opCode | input | 4 | Operation code |
| srcSel | input | 1 | ALU source: 0 accumulator, 1 product |
| shAmt | input | 6 | Shift amount or bit index |
| xIn | input | 16 | Data for X load |
| yIn | input | 16 | Data for Y load |
| accExt | output | 8 | Accumulator guard bits 39:32 |
| accHi | output | 16 | Accumulator bits 31:16 |
| accLo | output | 16 | Accumulator bits 15:0 |
| prodHi | output | 16 | Product bits 31:16 |
| prodLo | output | 16 | Product bits 15:0 |
| ovfFlag | output | 1 | Sticky clamp indicator |

## Verification
X and Y are not outputs, so the bench sees a corrupted operand only on the next single-operand load. That load pairs the new value with the held one, and the product on the outputs is wrong one cycle later. A wrong guard byte or a wrong sign in the accumulator appears in `accExt` at once. It also steers the next clamp to the wrong rail, which shows one operation later. A flag that clears on its own is caught by checking it after a later clamp of an in-range value.

// File: rtl/fmac_pkg.sv
package fmac_pkg;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_ASL,
    ALU_ASR,
    ALU_LSR,
    ALU_TGL,
    ALU_LIM
  } aluOp_e;

  typedef struct packed {
    logic   ldX;
    logic   ldY;
    logic   accumP;
    logic   wrAcc;
    aluOp_e alu;
  } strobe_t;

  localparam logic [3:0] OP_NOP  = 4'd0;
  localparam logic [3:0] OP_LDX  = 4'd1;
  localparam logic [3:0] OP_LDY  = 4'd2;
  localparam logic [3:0] OP_MAC  = 4'd3;
  localparam logic [3:0] OP_LDXY = 4'd4;
  localparam logic [3:0] OP_ADD  = 4'd5;
  localparam logic [3:0] OP_SUB  = 4'd6;
  localparam logic [3:0] OP_ASL  = 4'd7;
  localparam logic [3:0] OP_ASR  = 4'd8;
  localparam logic [3:0] OP_LSR  = 4'd9;
  localparam logic [3:0] OP_TGL  = 4'd10;
  localparam logic [3:0] OP_LIM  = 4'd11;

endpackage

// File: rtl/fmac_ctrl.sv
module fmac_ctrl
  import fmac_pkg::*;
(
  input  logic       opValid,
  input  logic [3:0] opCode,
  output strobe_t    strobes
);

  always_comb begin
    strobes = '{ldX: 1'b0, ldY: 1'b0, accumP: 1'b0, wrAcc: 1'b0, alu: ALU_ADD};
    if (opValid) begin
      unique case (opCode)
        OP_LDX:  strobes.ldX = 1'b1;
        OP_LDY:  strobes.ldY = 1'b1;
        OP_MAC: begin
          strobes.ldX    = 1'b1;
          strobes.ldY    = 1'b1;
          strobes.accumP = 1'b1;
        end
        OP_LDXY: begin
          strobes.ldX = 1'b1;
          strobes.ldY = 1'b1;
        end
        OP_ADD: begin strobes.wrAcc = 1'b1; strobes.alu = ALU_ADD; end
        OP_SUB: begin strobes.wrAcc = 1'b1; strobes.alu = ALU_SUB; end
        OP_ASL: begin strobes.wrAcc = 1'b1; strobes.alu = ALU_ASL; end
        OP_ASR: begin strobes.wrAcc = 1'b1; strobes.alu = ALU_ASR; end
        OP_LSR: begin strobes.wrAcc = 1'b1; strobes.alu = ALU_LSR; end
        OP_TGL: begin strobes.wrAcc = 1'b1; strobes.alu = ALU_TGL; end
        OP_LIM: begin strobes.wrAcc = 1'b1; strobes.alu = ALU_LIM; end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/fmac_dp.sv
module fmac_dp
  import fmac_pkg::*;
#(
  parameter int DW = 16,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strobes,
  input  logic          srcSel,
  input  logic [5:0]    shAmt,
  input  logic [DW-1:0] xIn,
  input  logic [DW-1:0] yIn,
  output logic [2*DW+GW-1:0] accOut,
  output logic [2*DW-1:0]    prodOut,
  output logic          ovfOut
);

  localparam int PW = 2 * DW;
  localparam int AW = PW + GW;
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
  localparam logic [PW-1:0] PMAX = {1'b0, {(PW-1){1'b1}}};
  localparam logic [AW-1:0] APOS = {{(GW+1){1'b0}}, {(PW-1){1'b1}}};
  localparam logic [AW-1:0] ANEG = {{(GW+1){1'b1}}, {(PW-1){1'b0}}};

  logic [DW-1:0] xReg, yReg, xNext, yNext;
  logic [PW-1:0] prodReg, mulRes, prodNext;
  logic [AW-1:0] accReg, aluSrc, aluRes;
  logic          ovfReg, accInRange;
  logic signed [PW-1:0] rawMul;

  // Operand selection: a load takes the input, otherwise the held value.
  assign xNext  = strobes.ldX ? xIn : xReg;
  assign yNext  = strobes.ldY ? yIn : yReg;
  assign rawMul = $signed(xNext) * $signed(yNext);

  always_comb begin
    if (xNext == MINV && yNext == MINV) mulRes = PMAX;
    else                                mulRes = PW'(rawMul <<< 1);
    prodNext = strobes.accumP ? (prodReg + mulRes) : mulRes;
  end

  // ALU source and result.
  assign aluSrc     = srcSel ? {{GW{prodReg[PW-1]}}, prodReg} : accReg;
  assign accInRange = (&accReg[AW-1:PW-1]) | ~(|accReg[AW-1:PW-1]);

  always_comb begin
    unique case (strobes.alu)
      ALU_ADD: aluRes = accReg + aluSrc;
      ALU_SUB: aluRes = accReg - aluSrc;
      ALU_ASL: aluRes = aluSrc << shAmt;
      ALU_ASR: aluRes = AW'($signed(aluSrc) >>> shAmt);
      ALU_LSR: aluRes = aluSrc >> shAmt;
      ALU_TGL: aluRes = accReg ^ (AW'(1) << shAmt);
      ALU_LIM: aluRes = accInRange ? accReg : (accReg[AW-1] ? ANEG : APOS);
      default: aluRes = accReg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xReg    <= '0;
      yReg    <= '0;
      prodReg <= '0;
      accReg  <= '0;
      ovfReg  <= 1'b0;
    end else begin
      if (strobes.ldX) xReg <= xIn;
      if (strobes.ldY) yReg <= yIn;
      if (strobes.ldX || strobes.ldY) prodReg <= prodNext;
      if (strobes.wrAcc) begin
        accReg <= aluRes;
        if (strobes.alu == ALU_LIM && !accInRange) ovfReg <= 1'b1;
      end
    end
  end

  assign accOut  = accReg;
  assign prodOut = prodReg;
  assign ovfOut  = ovfReg;

  // R10: with no strobe active, the accumulator and the product hold.
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.ldX && !strobes.ldY && !strobes.wrAcc) |=>
      ($stable(accReg) && $stable(prodReg)));

  // R10: an operand load never touches the accumulator.
  assert_load_keeps_acc_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((strobes.ldX || strobes.ldY) && !strobes.wrAcc) |=> $stable(accReg));

  // R8: a bit toggle inside the word changes exactly one bit.
  assert_toggle_one_bit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrAcc && strobes.alu == ALU_TGL && shAmt < 6'(AW)) |=>
      ($countones(accReg ^ $past(accReg)) == 1));

  // R9: after a clamp the guard bits agree with bit 31.
  assert_limit_in_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrAcc && strobes.alu == ALU_LIM) |=>
      ((&accReg[AW-1:PW-1]) || !(|accReg[AW-1:PW-1])));

  // R9: the overflow flag never drops while out of reset.
  assert_sticky_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(ovfReg));

  // R3: the minus-one squared case lands on the positive rail.
  assert_minus_one_sq_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ldX && strobes.ldY && !strobes.accumP && xIn == MINV && yIn == MINV)
      |=> (prodReg == PMAX));

endmodule

// File: rtl/fmac_unit.sv
module fmac_unit
  import fmac_pkg::*;
#(
  parameter int DW = 16,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          opValid,
  input  logic [3:0]    opCode,
  input  logic          srcSel,
  input  logic [5:0]    shAmt,
  input  logic [DW-1:0] xIn,
  input  logic [DW-1:0] yIn,
  output logic [GW-1:0] accExt,
  output logic [DW-1:0] accHi,
  output logic [DW-1:0] accLo,
  output logic [DW-1:0] prodHi,
  output logic [DW-1:0] prodLo,
  output logic          ovfFlag
);

  localparam int PW = 2 * DW;
  localparam int AW = PW + GW;

  strobe_t       strobes;
  logic [AW-1:0] accBus;
  logic [PW-1:0] prodBus;

  fmac_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .strobes (strobes)
  );

  fmac_dp #(.DW(DW), .GW(GW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .srcSel  (srcSel),
    .shAmt   (shAmt),
    .xIn     (xIn),
    .yIn     (yIn),
    .accOut  (accBus),
    .prodOut (prodBus),
    .ovfOut  (ovfFlag)
  );

  assign accExt = accBus[AW-1:PW];
  assign accHi  = accBus[PW-1:DW];
  assign accLo  = accBus[DW-1:0];
  assign prodHi = prodBus[PW-1:DW];
  assign prodLo = prodBus[DW-1:0];

endmodule

// File: tb/sim_fmac_unit.sv
module sim_fmac_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid;
  logic [3:0]  opCode;
  logic        srcSel;
  logic [5:0]  shAmt;
  logic [15:0] xIn, yIn;
  logic [7:0]  accExt;
  logic [15:0] accHi, accLo, prodHi, prodLo;
  logic        ovfFlag;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  fmac_unit u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .srcSel(srcSel), .shAmt(shAmt), .xIn(xIn), .yIn(yIn),
    .accExt(accExt), .accHi(accHi), .accLo(accLo),
    .prodHi(prodHi), .prodLo(prodLo), .ovfFlag(ovfFlag)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] acc40();
    return {accExt, accHi, accLo};
  endfunction

  function automatic logic [31:0] prod32();
    return {prodHi, prodLo};
  endfunction

  task automatic doOp(logic [3:0] code, logic src, logic [5:0] amt,
                      logic [15:0] x, logic [15:0] y);
    @(negedge clk);
    opValid = 1'b1; opCode = code; srcSel = src; shAmt = amt; xIn = x; yIn = y;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testReset();
    doReset();
    check("R1 acc", 64'(acc40()), 64'h0);
    check("R1 prod", 64'(prod32()), 64'h0);
    check("R1 ovf", 64'(ovfFlag), 64'h0);
  endtask

  task automatic testLoads();
    doOp(4'd1, 1'b0, 6'd0, 16'h4000, 16'h0);     // X=0.5, Y=0
    check("R2 ldx with y zero", 64'(prod32()), 64'h0);
    doOp(4'd2, 1'b0, 6'd0, 16'h0, 16'h4000);     // Y=0.5 -> 0.25
    check("R2 ldy uses held x", 64'(prod32()), 64'h2000_0000);
    doOp(4'd1, 1'b0, 6'd0, 16'h2000, 16'h0);     // 0.25*0.5
    check("R2 ldx uses held y", 64'(prod32()), 64'h1000_0000);
    doOp(4'd4, 1'b0, 6'd0, 16'h8000, 16'h7FFF);
    check("R3 min times max", 64'(prod32()), 64'h8001_0000);
    doOp(4'd4, 1'b0, 6'd0, 16'h8000, 16'h8000);
    check("R3 minus one squared", 64'(prod32()), 64'h7FFF_FFFF);
    check("R10 loads keep acc", 64'(acc40()), 64'h0);
  endtask

  task automatic testMac();
    doOp(4'd4, 1'b0, 6'd0, 16'h4000, 16'h4000);
    check("R2 ldxy overwrites", 64'(prod32()), 64'h2000_0000);
    doOp(4'd3, 1'b0, 6'd0, 16'h4000, 16'h4000);
    check("R4 mac first", 64'(prod32()), 64'h4000_0000);
    doOp(4'd3, 1'b0, 6'd0, 16'h6000, 16'h4000);
    check("R4 mac second", 64'(prod32()), 64'h7000_0000);
  endtask

  task automatic testAddLimit();
    doOp(4'd5, 1'b1, 6'd0, 16'h0, 16'h0);
    check("R5 add product", 64'(acc40()), 64'h00_7000_0000);
    doOp(4'd5, 1'b1, 6'd0, 16'h0, 16'h0);
    check("R6 guard bits hold sum", 64'(acc40()), 64'h00_E000_0000);
    check("R9 flag clear before clamp", 64'(ovfFlag), 64'h0);
    doOp(4'd11, 1'b0, 6'd0, 16'h0, 16'h0);
    check("R9 positive clamp", 64'(acc40()), 64'h00_7FFF_FFFF);
    check("R9 flag set", 64'(ovfFlag), 64'h1);
    check("R10 alu keeps prod", 64'(prod32()), 64'h7000_0000);
    doOp(4'd6, 1'b0, 6'd0, 16'h0, 16'h0);
    check("R6 sub self", 64'(acc40()), 64'h0);
    doOp(4'd3, 1'b0, 6'd0, 16'h4000, 16'h4000);   // 0x7000_0000 + 0x2000_0000
    check("R4 mac wraps", 64'(prod32()), 64'h9000_0000);
  endtask

  task automatic testShifts();
    doOp(4'd4, 1'b0, 6'd0, 16'h8000, 16'h7FFF);    // prod 0x8001_0000
    doOp(4'd6, 1'b1, 6'd0, 16'h0, 16'h0);
    check("R6 sub product", 64'(acc40()), 64'h00_7FFF_0000);
    doOp(4'd7, 1'b0, 6'd4, 16'h0, 16'h0);
    check("R7 asl acc", 64'(acc40()), 64'h07_FFF0_0000);
    doOp(4'd8, 1'b0, 6'd8, 16'h0, 16'h0);
    check("R7 asr positive", 64'(acc40()), 64'h00_07FF_F000);
    doOp(4'd6, 1'b0, 6'd0, 16'h0, 16'h0);
    doOp(4'd5, 1'b1, 6'd0, 16'h0, 16'h0);
    check("R5 product sign extended", 64'(acc40()), 64'hFF_8001_0000);
    doOp(4'd8, 1'b0, 6'd4, 16'h0, 16'h0);
    check("R7 asr negative", 64'(acc40()), 64'hFF_F800_1000);
    doOp(4'd9, 1'b1, 6'd4, 16'h0, 16'h0);
    check("R7 lsr product source", 64'(acc40()), 64'h0F_F800_1000);
    doOp(4'd10, 1'b0, 6'd39, 16'h0, 16'h0);
    check("R8 toggle bit 39", 64'(acc40()), 64'h8F_F800_1000);
    doOp(4'd10, 1'b0, 6'd0, 16'h0, 16'h0);
    check("R8 toggle bit 0", 64'(acc40()), 64'h8F_F800_1001);
    doOp(4'd11, 1'b0, 6'd0, 16'h0, 16'h0);
    check("R9 negative clamp", 64'(acc40()), 64'hFF_8000_0000);
    doOp(4'd11, 1'b0, 6'd0, 16'h0, 16'h0);
    check("R9 in range unchanged", 64'(acc40()), 64'hFF_8000_0000);
    check("R9 flag sticky", 64'(ovfFlag), 64'h1);
  endtask

  task automatic testIdle();
    @(negedge clk);
    opValid = 1'b0; opCode = 4'd5; srcSel = 1'b1; xIn = 16'h7FFF; yIn = 16'h7FFF;
    @(negedge clk);
    check("R10 valid low acc", 64'(acc40()), 64'hFF_8000_0000);
    check("R10 valid low prod", 64'(prod32()), 64'h8001_0000);
    doOp(4'd0, 1'b1, 6'd3, 16'h7FFF, 16'h7FFF);
    doOp(4'd13, 1'b1, 6'd3, 16'h7FFF, 16'h7FFF);
    check("R10 nop acc", 64'(acc40()), 64'hFF_8000_0000);
    check("R10 nop prod", 64'(prod32()), 64'h8001_0000);
    doOp(4'd1, 1'b0, 6'd0, 16'h4000, 16'h0);       // held Y is still 0x7FFF
    check("R10 y held through nop", 64'(prod32()), 64'h3FFF_8000);
  endtask

  task automatic testResetAgain();
    doReset();
    check("R1 flag cleared by reset", 64'(ovfFlag), 64'h0);
    check("R1 acc cleared", 64'(acc40()), 64'h0);
  endtask

  initial begin
    rstN = 1'b0; opValid = 1'b0; opCode = '0; srcSel = 1'b0; shAmt = '0;
    xIn = '0; yIn = '0;
    repeat (2) @(negedge clk);
    testReset();
    testLoads();
    testMac();
    testAddLimit();
    testShifts();
    testIdle();
    testResetAgain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule